// File: doc/BRIEF.md
# Byte-wide USB FIFO bridge controller

This block sits between an external byte-wide USB FIFO device and two on-chip FIFOs. The device signals that it holds a received byte by pulling its active-low data-available flag low, and that it can accept a byte by pulling its active-low space-available flag low. The bridge answers with active-low read and write strobes. A receive controller moves each byte offered by the device into the local receive FIFO. A transmit controller takes bytes from the local transmit FIFO and writes them to the device.

Both device flags pass through a two-flop synchronizer before either controller uses them. Every strobe is held low for a fixed number of system clocks. After each strobe the line stays high for a recovery time, and the controller then waits until the device has shown, through its flag, that it took the handshake. The data bus is split into input, output and output-enable so that the pad ring can build the tri-state buffer. Output-enable is high only while the write strobe is low. The read and write strobes are never low together. When both directions are ready at once, the direction not served last goes first.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is asserted and after its release with no data offered, `usb_rd_n` and `usb_wr_n` are 1, and `usb_data_oe`, `rx_push` and `tx_pop` are 0.
- R2: A read begins only when the synchronized data-available flag is active and `rx_full` was 0 at the start decision. `usb_rd_n` then stays 0 for exactly STROBE_CLKS cycles.
- R3: The byte on `usb_data_in` is sampled in the last cycle that `usb_rd_n` is 0. It is written to the local FIFO by a single-cycle `rx_push` in the cycle in which `usb_rd_n` returns to 1. There is exactly one push per read strobe, and bytes arrive in device order.
- R4: After a read, `usb_rd_n` stays 1 for at least RECOVER_CLKS cycles. No further read begins until `usb_rxf_n` has been seen at 1 since the previous read ended, so no byte is read twice.
- R5: A write begins only when the synchronized space-available flag is active and `tx_empty` was 0 at the start decision. `tx_pop` is high for one cycle, two cycles before `usb_wr_n` falls, and `tx_pop_data` is taken in the cycle after `tx_pop`. Bytes reach the device in local FIFO order.
- R6: `usb_wr_n` stays 0 for exactly STROBE_CLKS cycles. `usb_data_oe` is 1 exactly while `usb_wr_n` is 0, and `usb_data_out` is stable for that whole window.
- R7: After a write, no further write begins until `usb_txe_n` has been seen at 1 since the previous write ended. A write strobe never falls while `usb_txe_n` is 1.
- R8: `usb_rd_n` and `usb_wr_n` are never 0 in the same cycle. With both directions continuously ready, both complete their traffic.
- R9: A low level on `usb_rxf_n` starts a read no earlier than the third rising clock edge after it is applied, the delay of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_rxf_n | input | 1 | Device has a byte to read (active low) |
| usb_txe_n | input | 1 | Device can accept a byte (active low) |
| usb_data_in | input | DATA_W | Data bus as driven by the device |
| usb_rd_n | output | 1 | Read strobe to the device (active low) |
| usb_wr_n | output | 1 | Write strobe to the device (active low) |
| usb_data_out | output | DATA_W | Data the bridge drives onto the bus |
| usb_data_oe | output | 1 | Output enable for the bus driver |
| rx_full | input | 1 | Local receive FIFO cannot take another byte |
| rx_push | output | 1 | Write one byte into the local receive FIFO |
| rx_push_data | output | DATA_W | Byte for the local receive FIFO |
| tx_empty | input | 1 | Local transmit FIFO holds no byte |
| tx_pop_data | input | DATA_W | Head of the local transmit FIFO, valid the cycle after a pop |
| tx_pop | output | 1 | Read one byte from the local transmit FIFO |

## Verification
The bench uses a behavioural device that raises its flag for a random number of cycles after every strobe, drains its own transmit space at random, and gains new bytes while transfers in the other direction are running. It also toggles the local full and empty inputs at random. A controller that re-reads while a stale synchronized flag still shows data would push a byte twice. A controller that waits only for the flag's rising edge could miss a short high pulse and stall. If the bus is released late or the data register is loaded early, the byte latched at the end of the write strobe changes. The bench also measures every strobe width and recovery gap, and checks that a read starts only after the flag has been low for three samples, which a one-flop or unsynchronized path would violate.

// File: rtl/usbfb_pkg.sv
package usbfb_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SEND   = 2'd1,
        RX_RELOAD = 2'd2,
        RX_EMPTY  = 2'd3
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE   = 3'd0,
        TX_FETCH  = 3'd1,
        TX_LOAD   = 3'd2,
        TX_STROBE = 3'd3,
        TX_SETTLE = 3'd4
    } tx_state_e;

    function automatic int larger_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/usbfb_sync.sv
module usbfb_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = async_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/usbfb_rx_ctrl.sv
module usbfb_rx_ctrl
    import usbfb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int STROBE_CLKS  = 3,
    parameter int RECOVER_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rxf_act,
    input  logic              loc_full,
    input  logic [DATA_W-1:0] dev_din,
    output logic              want,
    output logic              idle,
    output logic              rd_n,
    output logic              push,
    output logic [DATA_W-1:0] push_data
);
    localparam int              CNT_MAX = larger_of(STROBE_CLKS, RECOVER_CLKS);
    localparam int              CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]   STB_LD  = CW'(STROBE_CLKS - 1);
    localparam logic [CW-1:0]   REC_LD  = CW'(RECOVER_CLKS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic              seen;
        logic              rd_n;
        logic              push;
        logic [DATA_W-1:0] data;
    } rx_reg_t;

    rx_reg_t q, d;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (go) begin
                    d.st   = RX_SEND;
                    d.rd_n = 1'b0;
                    d.cnt  = STB_LD;
                end
            end
            RX_SEND: begin
                if (q.cnt == '0) begin
                    d.st   = RX_RELOAD;
                    d.rd_n = 1'b1;
                    d.push = 1'b1;
                    d.data = dev_din;
                    d.cnt  = REC_LD;
                    d.seen = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            RX_RELOAD: begin
                if (!rxf_act) d.seen = 1'b1;
                if (q.cnt == '0) d.st  = RX_EMPTY;
                else             d.cnt = q.cnt - 1'b1;
            end
            RX_EMPTY: begin
                if (!rxf_act || q.seen) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, cnt: '0, seen: 1'b0, rd_n: 1'b1,
                   push: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign idle      = (q.st == RX_IDLE);
    assign want      = idle && rxf_act && !loc_full;
    assign rd_n      = q.rd_n;
    assign push      = q.push;
    assign push_data = q.data;

    // strobe-width monitor for the checks below
    int unsigned lo_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lo_cnt_q <= 0;
        else if (!q.rd_n)  lo_cnt_q <= lo_cnt_q + 1;
        else               lo_cnt_q <= 0;
    end

    // R2
    rd_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rd_n) |-> ($past(rxf_act) && !$past(loc_full)));

    // R2
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rd_n) |-> (lo_cnt_q == STROBE_CLKS));

    // R3
    push_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> (q.rd_n && !$past(q.rd_n)));
endmodule

// File: rtl/usbfb_tx_ctrl.sv
module usbfb_tx_ctrl
    import usbfb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int STROBE_CLKS  = 3,
    parameter int RECOVER_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              txe_act,
    input  logic              loc_empty,
    input  logic [DATA_W-1:0] loc_data,
    output logic              want,
    output logic              idle,
    output logic              pop,
    output logic              wr_n,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);
    localparam int              CNT_MAX = larger_of(STROBE_CLKS, RECOVER_CLKS);
    localparam int              CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]   STB_LD  = CW'(STROBE_CLKS - 1);
    localparam logic [CW-1:0]   REC_LD  = CW'(RECOVER_CLKS - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CW-1:0]     cnt;
        logic              seen;
        logic              pop;
        logic              wr_n;
        logic              oe;
        logic [DATA_W-1:0] data;
    } tx_reg_t;

    tx_reg_t q, d;

    always_comb begin
        d     = q;
        d.pop = 1'b0;
        unique case (q.st)
            TX_IDLE: begin
                if (go) begin
                    d.st  = TX_FETCH;
                    d.pop = 1'b1;
                end
            end
            TX_FETCH: d.st = TX_LOAD;
            TX_LOAD: begin
                d.data = loc_data;
                d.st   = TX_STROBE;
                d.wr_n = 1'b0;
                d.oe   = 1'b1;
                d.cnt  = STB_LD;
            end
            TX_STROBE: begin
                if (q.cnt == '0) begin
                    d.st   = TX_SETTLE;
                    d.wr_n = 1'b1;
                    d.oe   = 1'b0;
                    d.cnt  = REC_LD;
                    d.seen = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            TX_SETTLE: begin
                if (!txe_act) d.seen = 1'b1;
                if (q.cnt != '0)                 d.cnt = q.cnt - 1'b1;
                else if (!txe_act || q.seen)     d.st  = TX_IDLE;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, cnt: '0, seen: 1'b0, pop: 1'b0,
                   wr_n: 1'b1, oe: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign idle = (q.st == TX_IDLE);
    assign want = idle && txe_act && !loc_empty;
    assign pop  = q.pop;
    assign wr_n = q.wr_n;
    assign oe   = q.oe;
    assign dout = q.data;

    int unsigned lo_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lo_cnt_q <= 0;
        else if (!q.wr_n)  lo_cnt_q <= lo_cnt_q + 1;
        else               lo_cnt_q <= 0;
    end

    // R5
    pop_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.wr_n) |-> $past(q.pop, 2));

    // R6
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wr_n) |-> (lo_cnt_q == STROBE_CLKS));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe == !q.wr_n);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.wr_n && !$fell(q.wr_n)) |-> $stable(q.data));
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
    import usbfb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int STROBE_CLKS  = 3,
    parameter int RECOVER_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_rxf_n,
    input  logic              usb_txe_n,
    input  logic [DATA_W-1:0] usb_data_in,
    output logic              usb_rd_n,
    output logic              usb_wr_n,
    output logic [DATA_W-1:0] usb_data_out,
    output logic              usb_data_oe,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_pop
);
    localparam int FLAG_W = 2;

    logic [FLAG_W-1:0] flags_s;
    logic rxf_act, txe_act;
    logic rx_want, rx_idle, rx_go;
    logic tx_want, tx_idle, tx_go;
    logic last_tx_q, last_tx_d;

    usbfb_sync #(.W(FLAG_W), .RST_VAL('1)) u_flag_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({usb_txe_n, usb_rxf_n}),
        .sync_o  (flags_s)
    );

    assign rxf_act = !flags_s[0];
    assign txe_act = !flags_s[1];

    // one side starts only while the other rests; ties go to the side not served last
    always_comb begin
        rx_go     = rx_want && tx_idle && (!tx_want ||  last_tx_q);
        tx_go     = tx_want && rx_idle && (!rx_want || !last_tx_q);
        last_tx_d = last_tx_q;
        if (tx_go)      last_tx_d = 1'b1;
        else if (rx_go) last_tx_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_tx_q <= 1'b0;
        else        last_tx_q <= last_tx_d;
    end

    usbfb_rx_ctrl #(
        .DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS), .RECOVER_CLKS(RECOVER_CLKS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rx_go),
        .rxf_act   (rxf_act),
        .loc_full  (rx_full),
        .dev_din   (usb_data_in),
        .want      (rx_want),
        .idle      (rx_idle),
        .rd_n      (usb_rd_n),
        .push      (rx_push),
        .push_data (rx_push_data)
    );

    usbfb_tx_ctrl #(
        .DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS), .RECOVER_CLKS(RECOVER_CLKS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (tx_go),
        .txe_act   (txe_act),
        .loc_empty (tx_empty),
        .loc_data  (tx_pop_data),
        .want      (tx_want),
        .idle      (tx_idle),
        .pop       (tx_pop),
        .wr_n      (usb_wr_n),
        .oe        (usb_data_oe),
        .dout      (usb_data_out)
    );

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!usb_rd_n && !usb_wr_n));

    // R8
    bus_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_data_oe |-> usb_rd_n);

    // R9
    rxf_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(usb_rd_n) |-> (!$past(usb_rxf_n) && !$past(usb_rxf_n, 2)));
endmodule

// File: tb/usb_fifo_bridge_tb.sv
`timescale 1ns/1ps
module usb_fifo_bridge_tb;
    localparam int DW       = 8;
    localparam int STB      = 3;
    localparam int REC      = 2;
    localparam int DEV_CAP  = 4;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          usb_rxf_n, usb_txe_n, usb_rd_n, usb_wr_n, usb_data_oe;
    logic [DW-1:0] usb_data_in, usb_data_out;
    logic          rx_full, rx_push, tx_empty, tx_pop;
    logic [DW-1:0] rx_push_data, tx_pop_data;

    usb_fifo_bridge #(.DATA_W(DW), .STROBE_CLKS(STB), .RECOVER_CLKS(REC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .usb_rxf_n(usb_rxf_n), .usb_txe_n(usb_txe_n), .usb_data_in(usb_data_in),
        .usb_rd_n(usb_rd_n), .usb_wr_n(usb_wr_n), .usb_data_out(usb_data_out),
        .usb_data_oe(usb_data_oe),
        .rx_full(rx_full), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_empty(tx_empty), .tx_pop_data(tx_pop_data), .tx_pop(tx_pop)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural model state
    logic [DW-1:0] dev_rxq[$];
    logic [DW-1:0] exp_rxq[$];
    logic [DW-1:0] src_txq[$];
    logic [DW-1:0] exp_txq[$];
    int  rx_tgt = 0, tx_tgt = 0, rx_gen = 0, tx_gen = 0, rx_got = 0, tx_got = 0;
    int  cyc = 0;
    bit  wd = 1'b0;
    bit  stall_mode = 1'b0;
    int  rxf_hold = 0, txe_hold = 0, dev_fill = 0;
    int  rd_lo = 0, rd_hi = 1000, wr_lo = 0, pop_age = 100;
    bit  prev_rd = 1'b1, prev_wr = 1'b1, rd_rose;
    bit  rxf_seen = 1'b1, txe_seen = 1'b1;
    bit  h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
    logic [DW-1:0] wr_lat, bt;

    initial begin
        usb_rxf_n = 1'b1; usb_txe_n = 1'b0; usb_data_in = '0;
        rx_full = 1'b0; tx_empty = 1'b1; tx_pop_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc >= WD_LIMIT) wd = 1'b1;
            if (rst_n) begin
                // R8 / R6 every cycle
                chk(!(!usb_rd_n && !usb_wr_n), "R8 strobes overlap", int'(usb_rd_n), 1);
                chk(usb_data_oe == !usb_wr_n, "R6 bus drive window", int'(usb_data_oe), int'(!usb_wr_n));

                // local transmit FIFO
                pop_age++;
                if (tx_pop) begin
                    chk(!tx_empty, "R5 pop while empty flagged", int'(tx_empty), 0);
                    chk(src_txq.size() > 0, "R5 pop with no data", src_txq.size(), 1);
                    pop_age = 0;
                    if (src_txq.size() > 0) begin
                        bt = src_txq.pop_front();
                        tx_pop_data = bt;
                        exp_txq.push_back(bt);
                    end
                end

                // read strobe edges
                rd_rose = 1'b0;
                if (prev_rd && !usb_rd_n) begin
                    chk(!h1 && !h2 && !h3, "R9 RXF synchronised", int'({h3, h2, h1}), 0);
                    chk(rd_hi >= REC, "R4 RD recovery", rd_hi, REC);
                    chk(rxf_seen, "R4 RXF seen high before reread", int'(rxf_seen), 1);
                    chk(!rx_full, "R2 read while local full", int'(rx_full), 0);
                    chk(dev_rxq.size() > 0, "R2 read with no byte", dev_rxq.size(), 1);
                    rd_lo = 0;
                end
                if (!prev_rd && usb_rd_n) begin
                    chk(rd_lo == STB, "R2 RD width", rd_lo, STB);
                    rd_rose = 1'b1;
                    rd_hi = 0;
                    if (dev_rxq.size() > 0) void'(dev_rxq.pop_front());
                    rxf_hold = 1 + int'($urandom % 4);
                    rxf_seen = 1'b0;
                end
                if (!usb_rd_n) rd_lo++; else rd_hi++;

                // local receive FIFO
                chk(rx_push == rd_rose, "R3 push timing", int'(rx_push), int'(rd_rose));
                if (rx_push) begin
                    if (exp_rxq.size() == 0) begin
                        chk(1'b0, "R3 extra byte", int'(rx_push_data), -1);
                    end else begin
                        bt = exp_rxq.pop_front();
                        chk(rx_push_data == bt, "R3 pushed byte", int'(rx_push_data), int'(bt));
                        rx_got++;
                    end
                end

                // write strobe edges
                if (prev_wr && !usb_wr_n) begin
                    chk(!usb_txe_n, "R7 write while device full", int'(usb_txe_n), 0);
                    chk(txe_seen, "R7 TXE seen high before rewrite", int'(txe_seen), 1);
                    chk(pop_age == 2, "R5 pop to WR spacing", pop_age, 2);
                    wr_lo = 0;
                    wr_lat = usb_data_out;
                end
                if (!usb_wr_n) begin
                    wr_lo++;
                    chk(usb_data_out == wr_lat, "R6 data stable", int'(usb_data_out), int'(wr_lat));
                end
                if (!prev_wr && usb_wr_n) begin
                    chk(wr_lo == STB, "R6 WR width", wr_lo, STB);
                    if (exp_txq.size() == 0) begin
                        chk(1'b0, "R5 extra write", int'(wr_lat), -1);
                    end else begin
                        bt = exp_txq.pop_front();
                        chk(wr_lat == bt, "R5 written byte", int'(wr_lat), int'(bt));
                        tx_got++;
                    end
                    dev_fill++;
                    txe_hold = 1 + int'($urandom % 3);
                    txe_seen = 1'b0;
                end

                // traffic sources
                if (rx_gen < rx_tgt && ($urandom % 3) == 0) begin
                    bt = DW'($urandom);
                    dev_rxq.push_back(bt);
                    exp_rxq.push_back(bt);
                    rx_gen++;
                end
                if (tx_gen < tx_tgt && ($urandom % 3) == 0) begin
                    src_txq.push_back(DW'($urandom));
                    tx_gen++;
                end
                if (dev_fill > 0 && ($urandom % 3) == 0) dev_fill--;

                // device flags and data
                if (usb_rd_n) begin
                    if (rxf_hold > 0) begin usb_rxf_n = 1'b1; rxf_hold--; end
                    else usb_rxf_n = (dev_rxq.size() == 0);
                end
                if (usb_wr_n) begin
                    if (txe_hold > 0) begin usb_txe_n = 1'b1; txe_hold--; end
                    else usb_txe_n = (dev_fill >= DEV_CAP);
                end
                if (usb_rxf_n) rxf_seen = 1'b1;
                if (usb_txe_n) txe_seen = 1'b1;
                h3 = h2; h2 = h1; h1 = usb_rxf_n;
                usb_data_in = (!usb_rd_n && dev_rxq.size() > 0) ? dev_rxq[0] : 8'hA5;

                if (stall_mode) begin
                    if (($urandom % 8) == 0) rx_full = !rx_full;
                    tx_empty = (src_txq.size() == 0) || (($urandom % 4) == 0);
                end else begin
                    rx_full  = 1'b0;
                    tx_empty = (src_txq.size() == 0);
                end

                prev_rd = usb_rd_n;
                prev_wr = usb_wr_n;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(usb_rd_n == 1'b1, "R1 RD in reset", int'(usb_rd_n), 1);
        chk(usb_wr_n == 1'b1, "R1 WR in reset", int'(usb_wr_n), 1);
        chk(usb_data_oe == 1'b0, "R1 OE in reset", int'(usb_data_oe), 0);
        chk(rx_push == 1'b0 && tx_pop == 1'b0, "R1 FIFO enables in reset", int'({rx_push, tx_pop}), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1 after release with nothing offered
        chk(usb_rd_n && usb_wr_n, "R1 idle strobes", int'({usb_rd_n, usb_wr_n}), 3);
        chk(!usb_data_oe && !rx_push && !tx_pop, "R1 idle enables",
            int'({usb_data_oe, rx_push, tx_pop}), 0);

        // receive only
        rx_tgt = 100;
        while (rx_got < 100 && !wd) @(negedge clk);
        chk(tx_got == 0, "R8 no write without data", tx_got, 0);
        // transmit only
        tx_tgt = 100;
        while (tx_got < 100 && !wd) @(negedge clk);
        // both directions with random stalls
        stall_mode = 1'b1;
        rx_tgt = 400;
        tx_tgt = 400;
        while ((rx_got < 400 || tx_got < 400) && !wd) @(negedge clk);
        stall_mode = 1'b0;
        repeat (30) @(negedge clk);

        chk(!wd, "R8 watchdog", cyc, WD_LIMIT);
        chk(rx_got == 400, "R3 receive count", rx_got, 400);
        chk(tx_got == 400, "R5 transmit count", tx_got, 400);
        chk(dev_rxq.size() == 0 && exp_rxq.size() == 0, "R4 no byte left or repeated",
            dev_rxq.size() + exp_rxq.size(), 0);
        chk(exp_txq.size() == 0 && src_txq.size() == 0, "R7 no byte left",
            exp_txq.size() + src_txq.size(), 0);
        chk(usb_rd_n && usb_wr_n && !usb_data_oe, "R8 quiet at end",
            int'({usb_rd_n, usb_wr_n, usb_data_oe}), 6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule